// File: doc/BRIEF.md
# Page Write Controller With Toggle Status

This block gathers a burst of byte writes into a page buffer and then runs a timed program cycle that moves the gathered bytes into a storage array. The first write that arrives while the block is idle opens a page. The page is the upper part of the 15-bit address, `wr_addr[14:7]`, and the byte offset inside it is `wr_addr[6:0]`. Every later write to the same page lands in the buffer and marks its slot as loaded. A write to any other page is dropped and flagged on `wr_err`.

Each rise of the host data strobe restarts a byte-load timer, and so does each accepted write. When the timer runs out with no new activity, loading ends and the program cycle starts. `busy` then stays high for a fixed number of clocks. During the first 128 clocks of that window the block walks the buffer in ascending offset order. For every loaded slot it raises `commit_en` with the full address and the byte, so the array can store it.

While `busy` is high the array cannot be read. A read request instead returns a status byte one clock later, and bit 6 of that byte flips on every read. When `busy` falls, status answers stop and the array serves reads again. Both timer lengths are parameters counted in clock cycles.

Top module: `page_write_ctrl`

## Requirements
- R1: A write (`wr_valid`) taken while idle opens a page whose number is `wr_addr[14:7]`, and stores the byte at offset `wr_addr[6:0]`.
- R2: While a page is loading, a write whose `wr_addr[14:7]` equals the open page is stored. A write to a different page is not stored, and `wr_err` is high for exactly the one clock after the edge that sampled that write.
- R3: A `strobe_rise` or an accepted write restarts the load timer. `busy` first reads high exactly `LOAD_TIMEOUT` clocks after the last restart edge.
- R4: `busy` stays high for exactly `PROG_CYCLES` consecutive clocks per program cycle.
- R5: During the first 128 busy clocks, `commit_en` pulses once per loaded offset, in ascending offset order. Each pulse carries `commit_addr = {page, offset}` and the byte written last to that offset. Offsets never written produce no pulse.
- R6: Writes presented while `busy` is high are ignored. They raise no `wr_err`, open no page and cause no commit.
- R7: A `rd_req` sampled while busy gives `stat_valid` high on the next clock. `stat_data` bit 6 holds the toggle value and all other bits are 0. Within one program cycle, successive reads return opposite values of bit 6.
- R8: A `rd_req` sampled while not busy leaves `stat_valid` low.
- R9: The first status read of every program cycle returns bit 6 equal to 0, whatever the previous cycle ended with.
- R10: A page with all 128 offsets loaded commits all 128 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Byte write present this clock |
| wr_addr | input | 15 | Write address: page in [14:7], offset in [6:0] |
| wr_data | input | 8 | Write byte |
| strobe_rise | input | 1 | One-clock pulse on each rise of the host data strobe |
| rd_req | input | 1 | Read access request |
| commit_en | output | 1 | Array write enable during programming |
| commit_addr | output | 15 | Array address for the committed byte |
| commit_data | output | 8 | Committed byte |
| busy | output | 1 | Program cycle in progress |
| stat_valid | output | 1 | Status byte valid (read taken while busy) |
| stat_data | output | 8 | Status byte, toggle in bit 6 |
| wr_err | output | 1 | One-clock pulse for a write to a foreign page |

## Verification
A timer that reloads on the wrong event, or counts one clock too many or too few, moves the rise of `busy` off its expected clock. It shows on the very first page. A loaded mask that is stale or not cleared shows as an extra, missing or out-of-order `commit_en` within the first 128 busy clocks, and the scoreboard catches it on that pulse. A toggle that is not restarted, or that advances on non-busy reads, shows at the first status read of the next program cycle.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    localparam int ADDR_W     = 15;
    localparam int DATA_W     = 8;
    localparam int PAGE_BYTES = 128;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int PAGE_W     = ADDR_W - OFF_W;
    localparam int STAT_BIT   = 6;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } state_e;

    typedef struct packed {
        logic  en;
        addr_t addr;
        data_t data;
    } commit_t;

    function automatic page_t page_of(addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic off_t off_of(addr_t a);
        return a[OFF_W-1:0];
    endfunction

    function automatic data_t status_byte(logic tog);
        data_t s;
        s = '0;
        s[STAT_BIT] = tog;
        return s;
    endfunction

endpackage

// File: rtl/pwc_page_buffer.sv
module pwc_page_buffer
    import pwc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  off_t  wr_off,
    input  data_t wr_data,
    input  logic  clr,
    input  off_t  rd_off,
    output data_t rd_data,
    output logic  rd_loaded
);

    data_t                 store [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded;
    logic [PAGE_BYTES-1:0] hit;

    // one-hot slot select for the incoming byte
    generate
        for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_hit
            assign hit[i] = wr_en && (wr_off == off_t'(i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            loaded <= '0;
        end else begin
            loaded <= loaded | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_off] <= wr_data;
        end
    end

    assign rd_data   = store[rd_off];
    assign rd_loaded = loaded[rd_off];

endmodule

// File: rtl/pwc_retrig_timer.sv
module pwc_retrig_timer #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic reload,
    output logic expire
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    assign expire = run && !reload && (cnt == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (reload) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwc_toggle_status.sv
module pwc_toggle_status
    import pwc_pkg::*;
#(
    parameter logic TOGGLE_FIRST = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  busy,
    input  logic  rd_req,
    output logic  stat_valid,
    output data_t stat_data
);

    logic tog;
    logic take;

    assign take = busy && rd_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog        <= TOGGLE_FIRST;
            stat_valid <= 1'b0;
            stat_data  <= '0;
        end else begin
            stat_valid <= take;
            stat_data  <= take ? status_byte(tog) : '0;
            if (start) begin
                tog <= TOGGLE_FIRST;
            end else if (take) begin
                tog <= ~tog;
            end
        end
    end

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
    import pwc_pkg::*;
#(
    parameter int LOAD_TIMEOUT = 10000,
    parameter int PROG_CYCLES  = 500000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                strobe_rise,
    input  logic                rd_req,
    output logic                commit_en,
    output logic [ADDR_W-1:0]   commit_addr,
    output logic [DATA_W-1:0]   commit_data,
    output logic                busy,
    output logic                stat_valid,
    output logic [DATA_W-1:0]   stat_data,
    output logic                wr_err
);

    localparam int PCNT_W = $clog2(PROG_CYCLES + 1);

    state_e           state;
    page_t            page_q;
    logic [PCNT_W-1:0] prog_cnt;

    logic    same_page;
    logic    accept_wr;
    logic    foreign_wr;
    logic    load_done;
    logic    prog_last;
    logic    walking;
    off_t    walk_off;
    data_t   buf_data;
    logic    buf_loaded;
    commit_t cmt;

    assign same_page  = (page_of(wr_addr) == page_q);
    assign accept_wr  = wr_valid && ((state == ST_IDLE) ||
                                     (state == ST_LOAD && same_page));
    assign foreign_wr = wr_valid && (state == ST_LOAD) && !same_page;
    assign prog_last  = (state == ST_PROG) && (prog_cnt == PCNT_W'(PROG_CYCLES - 1));
    assign walking    = (state == ST_PROG) && (prog_cnt < PCNT_W'(PAGE_BYTES));
    assign walk_off   = prog_cnt[OFF_W-1:0];
    assign busy       = (state == ST_PROG);

    pwc_retrig_timer #(
        .LIMIT (LOAD_TIMEOUT)
    ) u_load_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_LOAD),
        .reload (strobe_rise || accept_wr),
        .expire (load_done)
    );

    pwc_page_buffer u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept_wr),
        .wr_off    (off_of(wr_addr)),
        .wr_data   (wr_data),
        .clr       (prog_last),
        .rd_off    (walk_off),
        .rd_data   (buf_data),
        .rd_loaded (buf_loaded)
    );

    pwc_toggle_status #(
        .TOGGLE_FIRST (1'b0)
    ) u_status (
        .clk        (clk),
        .rst        (rst),
        .start      (load_done),
        .busy       (busy),
        .rd_req     (rd_req),
        .stat_valid (stat_valid),
        .stat_data  (stat_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            page_q   <= '0;
            prog_cnt <= '0;
            wr_err   <= 1'b0;
        end else begin
            wr_err <= foreign_wr;
            case (state)
                ST_IDLE: begin
                    if (wr_valid) begin
                        state  <= ST_LOAD;
                        page_q <= page_of(wr_addr);
                    end
                end
                ST_LOAD: begin
                    if (load_done) begin
                        state    <= ST_PROG;
                        prog_cnt <= '0;
                    end
                end
                ST_PROG: begin
                    if (prog_last) begin
                        state <= ST_IDLE;
                    end else begin
                        prog_cnt <= prog_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmt.en   = walking && buf_loaded;
        cmt.addr = {page_q, walk_off};
        cmt.data = buf_data;
    end

    assign commit_en   = cmt.en;
    assign commit_addr = cmt.addr;
    assign commit_data = cmt.data;

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker
    import pwc_pkg::*;
#(
    parameter int PROG_CYCLES = 500000
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              rd_req,
    input logic              commit_en,
    input logic [ADDR_W-1:0] commit_addr,
    input logic              busy,
    input logic              stat_valid,
    input logic [DATA_W-1:0] stat_data,
    input logic              wr_err
);

    localparam int RUN_W = $clog2(PROG_CYCLES + 2);

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(run_len) == RUN_W'(PROG_CYCLES - 1)));

    // R5
    commit_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        commit_en |-> busy);

    // R5
    commit_page_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_en && $past(commit_en)) |->
        (commit_addr[ADDR_W-1:OFF_W] == $past(commit_addr[ADDR_W-1:OFF_W])));

    // R7
    stat_cause_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> ($past(rd_req) && $past(busy)));

    // R7
    stat_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && $past(stat_valid) && busy && $past(busy)) |->
        (stat_data[STAT_BIT] != $past(stat_data[STAT_BIT])));

    // R7
    stat_clean_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> ((stat_data & ~status_byte(1'b1)) == '0));

    // R2
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_valid));

endmodule

bind page_write_ctrl pwc_checker #(
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .rd_req      (rd_req),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .busy        (busy),
    .stat_valid  (stat_valid),
    .stat_data   (stat_data),
    .wr_err      (wr_err)
);

// File: tb/page_write_ctrl_test.sv
module page_write_ctrl_test;

    localparam int T_LOAD = 20;
    localparam int T_PROG = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        strobe_rise = 1'b0;
    logic        rd_req = 1'b0;
    logic        commit_en;
    logic [14:0] commit_addr;
    logic [7:0]  commit_data;
    logic        busy;
    logic        stat_valid;
    logic [7:0]  stat_data;
    logic        wr_err;

    int checks = 0;
    int errors = 0;
    int commits_seen = 0;
    int last_run = 0;
    int run = 0;

    logic [22:0] expq [$];
    logic [7:0]  exp_data [128];
    bit          exp_mask [128];
    logic [7:0]  arr [int];

    always #5 clk = ~clk;

    page_write_ctrl #(
        .LOAD_TIMEOUT (T_LOAD),
        .PROG_CYCLES  (T_PROG)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .strobe_rise (strobe_rise),
        .rd_req      (rd_req),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .busy        (busy),
        .stat_valid  (stat_valid),
        .stat_data   (stat_data),
        .wr_err      (wr_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: commits popped in order, array model updated
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) run++;
            else if (run != 0) begin
                last_run = run;
                run = 0;
            end
            if (commit_en) begin
                logic [22:0] e;
                commits_seen++;
                arr[int'(commit_addr)] = commit_data;
                if (expq.size() == 0) begin
                    chk(1'b0, "R5", "unexpected commit", int'(commit_addr), 0);
                end else begin
                    e = expq.pop_front();
                    chk({commit_addr, commit_data} == e, "R1 R5",
                        "commit addr/data", int'({commit_addr, commit_data}), int'(e));
                end
            end
        end
    end

    // write task: strobe and data in the same clock
    task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit model);
        wr_valid = 1'b1;
        strobe_rise = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        strobe_rise = 1'b0;
        if (model) begin
            exp_mask[a[6:0]] = 1'b1;
            exp_data[a[6:0]] = d;
        end
    endtask

    task automatic flush(input logic [7:0] pg);
        for (int i = 0; i < 128; i++) begin
            if (exp_mask[i]) expq.push_back({pg, 7'(i), exp_data[i]});
            exp_mask[i] = 1'b0;
        end
    endtask

    task automatic measure_rise(output int n);
        n = 0;
        while (!busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic rd_burst(input int k, input bit exp_v, input bit first, input string req);
        rd_req = 1'b1;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (i == k - 1) rd_req = 1'b0;
            chk(stat_valid == exp_v, req, "stat_valid", int'(stat_valid), int'(exp_v));
            if (exp_v) begin
                chk(stat_data == {1'b0, first ^ i[0], 6'b0}, req, "stat_data",
                    int'(stat_data), int'({1'b0, first ^ i[0], 6'b0}));
            end
        end
        rd_req = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin
            @(negedge clk);
            g++;
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < 128; i++) exp_mask[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R4", "reset busy", int'(busy), 0);
        chk(commit_en == 1'b0, "R5", "reset commit_en", int'(commit_en), 0);
        chk(stat_valid == 1'b0, "R8", "reset stat_valid", int'(stat_valid), 0);
        chk(wr_err == 1'b0, "R2", "reset wr_err", int'(wr_err), 0);

        // page 0x12: overwrite, foreign write, measured timeout
        wr({8'h12, 7'd3}, 8'hA1, 1'b1);
        wr({8'h12, 7'd10}, 8'h5B, 1'b1);
        chk(wr_err == 1'b0, "R2", "no err same page", int'(wr_err), 0);
        wr({8'h13, 7'd5}, 8'hEE, 1'b0);
        chk(wr_err == 1'b1, "R2", "err pulse", int'(wr_err), 1);
        wr({8'h12, 7'd10}, 8'hC4, 1'b1);
        chk(wr_err == 1'b0, "R2", "err one clock", int'(wr_err), 0);
        wr({8'h12, 7'd64}, 8'h77, 1'b1);
        flush(8'h12);
        measure_rise(n);
        chk(n == T_LOAD, "R3", "busy rise after write", n, T_LOAD);
        rd_burst(4, 1'b1, 1'b0, "R7");
        wr({8'h20, 7'd0}, 8'h99, 1'b0);
        chk(wr_err == 1'b0, "R6", "no err while busy", int'(wr_err), 0);
        wait_idle();
        chk(last_run == T_PROG, "R4", "busy length", last_run, T_PROG);
        rd_burst(2, 1'b0, 1'b0, "R8");
        repeat (T_LOAD + 5) @(negedge clk);
        chk(busy == 1'b0, "R6", "busy write opened no page", int'(busy), 0);
        chk(arr.exists(int'({8'h12, 7'd10})) && arr[int'({8'h12, 7'd10})] == 8'hC4,
            "R5", "array holds last value", 0, 8'hC4);

        // page 0x05: strobe-only retrigger, toggle restart
        wr({8'h05, 7'd127}, 8'h3C, 1'b1);
        flush(8'h05);
        repeat (10) @(negedge clk);
        strobe_rise = 1'b1;
        @(negedge clk);
        strobe_rise = 1'b0;
        measure_rise(n);
        chk(n == T_LOAD, "R3", "busy rise after strobe", n, T_LOAD);
        rd_burst(3, 1'b1, 1'b0, "R9");
        wait_idle();
        chk(last_run == T_PROG, "R4", "busy length 2", last_run, T_PROG);

        // full page 0x7F
        for (int i = 0; i < 128; i++) wr({8'h7F, 7'(i)}, 8'(i * 3 + 1), 1'b1);
        flush(8'h7F);
        measure_rise(n);
        chk(n == T_LOAD, "R3", "busy rise full page", n, T_LOAD);
        rd_burst(1, 1'b1, 1'b0, "R9");
        wait_idle();
        chk(commits_seen == 3 + 1 + 128, "R10", "total commits", commits_seen, 132);
        chk(expq.size() == 0, "R5", "scoreboard drained", expq.size(), 0);
        chk(arr.exists(int'({8'h7F, 7'd127})) && arr[int'({8'h7F, 7'd127})] == 8'(127 * 3 + 1),
            "R10", "last byte of full page", 0, 8'(127 * 3 + 1));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule